// File: doc/BRIEF.md
# Prioritised interrupt request controller

This block collects interrupt requests from three kinds of source and turns them into a single request for the processor. The sources are one non-maskable line, eight external request pins and eight on-chip peripheral request lines. Each source is conditioned first. The non-maskable line detects an edge whose direction can be chosen. Each external pin is sensed either on a low level or on a falling edge. Every source other than the non-maskable one is gated by its own enable bit.

Edge-sensed requests are held in pending latches until the processor acknowledges them. Each cycle, a fixed-priority arbiter picks the highest-priority pending request and presents its vector number together with a flag that marks it as non-maskable. The processor's global mask bit hides every maskable request while it is set. The non-maskable request is never hidden.

The enable and sense bits are written through a small synchronous write port. The processor accepts the presented request by pulsing `irq_ack` in a cycle where `irq_valid` is high. This pulse clears the pending latch of the source shown in that cycle. The presented vector may change from one cycle to the next if a higher-priority request arrives first. `irq_ack` asserted while `irq_valid` is low is ignored.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0. All enables are 0, all external pins are in level mode, and the non-maskable line senses falling edges. The synchronisers reset to the high (idle) level.
- R2: The non-maskable line sets its pending request on a falling edge when its edge-select bit is 0, and on a rising edge when the bit is 1. The edge in the other direction is ignored.
- R3: A pending non-maskable request is presented with `irq_valid`=1, `irq_vec`=0 and `irq_nmi`=1, whatever the global mask and the enable bits hold.
- R4: A second non-maskable edge that arrives while the first is still unacknowledged is merged into it, so a single acknowledge leaves no request.
- R5: An external pin in level mode requests while it is low and enabled. The request follows the pin, and an acknowledge does not remove it.
- R6: An external pin in edge mode latches a request on a falling edge. The latch stays set after the pin returns high, until the request is acknowledged.
- R7: A disabled source is never presented. An edge that arrives on a disabled pin is not latched, so enabling the pin afterwards produces no request.
- R8: Priority runs from highest to lowest as: non-maskable, external pin 0 to 7, then peripheral line 0 to 7. The vector is 0 for the non-maskable line, 1+i for external pin i, and 9+j for peripheral line j.
- R9: Requests that lose arbitration stay pending. After the winner is acknowledged, the next one is presented.
- R10: While `mask_i` is 1, no maskable request is presented, but maskable requests stay pending. They are presented once `mask_i` returns to 0.
- R11: Writes use `wr_en` and `wr_addr`. Address 0 holds the external enable bits (bit i is pin i). Address 1 holds the external sense bits (1 selects falling edge, 0 selects low level). Address 2 holds the peripheral enable bits. Address 3 holds, in bit 0, the non-maskable edge select (1 selects rising).
- R12: `irq_ack` with `irq_valid` high clears only the source presented in that cycle. `irq_ack` with `irq_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register select |
| wr_data | input | 8 | Configuration write data |
| nmi_pin | input | 1 | Non-maskable request line (asynchronous) |
| ext_pin | input | 8 | External request pins, active low (asynchronous) |
| periph_req | input | 8 | On-chip peripheral request lines, active high |
| mask_i | input | 1 | Global mask bit from the processor |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 5 | Vector number of the presented request |
| irq_nmi | output | 1 | The presented request is non-maskable |
| irq_ack | input | 1 | One-cycle acknowledge of the presented request |

## Verification
Any corruption of a pending latch, an edge detector or a configuration bit shows at the ports. It can appear as a wrong vector, a request that appears or persists when it should not, or one that is missing. A pin change takes two clocks to reach a level-sensed request and three clocks to reach an edge-sensed one. A bad latch shows up on the next arbitration, at the latest once the higher-priority requests have been acknowledged or the mask has been lifted. The stimulus therefore steps through priority ladders, acknowledge chains and mask toggles, so that every latch is eventually the winner.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    CFG_EXT_EN   = 2'd0,
    CFG_EXT_EDGE = 2'd1,
    CFG_PER_EN   = 2'd2,
    CFG_NMI      = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  // Two-stage synchroniser, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_ext_src.sv
module irqc_ext_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic en,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic prev_q, latch_q, fall;

  assign fall = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (!edge_mode)
        latch_q <= 1'b0;
      else if (fall && en)
        latch_q <= 1'b1;
      else if (clr)
        latch_q <= 1'b0;
    end
  end

  assign req = en & (edge_mode ? latch_q : ~pin_s);
endmodule

// File: rtl/irqc_nmi_src.sv
module irqc_nmi_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic rise_sel,
  input  logic clr,
  output logic set,
  output logic pend
);
  logic prev_q;

  assign set = rise_sel ? (~prev_q & pin_s) : (prev_q & ~pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend   <= (pend & ~clr) | set;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 17,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int N_EXT    = 8,
  parameter int N_PERIPH = 8,
  parameter int DW       = 8,
  localparam int N_SRC   = 1 + N_EXT + N_PERIPH,
  localparam int VEC_W   = $clog2(N_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                nmi_pin,
  input  logic [N_EXT-1:0]    ext_pin,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic                mask_i,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vec,
  output logic                irq_nmi,
  input  logic                irq_ack
);
  import irqc_pkg::*;

  localparam int PER_BASE = 1 + N_EXT;

  logic [N_EXT-1:0]    ext_en_q, ext_edge_q;
  logic [N_PERIPH-1:0] per_en_q;
  logic                nmi_rise_q;
  logic                nmi_s;
  logic [N_EXT-1:0]    ext_s;
  logic [N_SRC-1:0]    src_req, arb_req, clr;
  logic                nmi_set, nmi_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en_q   <= '0;
      ext_edge_q <= '0;
      per_en_q   <= '0;
      nmi_rise_q <= 1'b0;
    end else if (wr_en) begin
      case (cfg_addr_e'(wr_addr))
        CFG_EXT_EN:   ext_en_q   <= wr_data[N_EXT-1:0];
        CFG_EXT_EDGE: ext_edge_q <= wr_data[N_EXT-1:0];
        CFG_PER_EN:   per_en_q   <= wr_data[N_PERIPH-1:0];
        default:      nmi_rise_q <= wr_data[0];
      endcase
    end
  end

  irqc_sync #(.W(N_EXT + 1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nmi_pin, ext_pin}),
    .q     ({nmi_s, ext_s})
  );

  assign clr = (irq_valid && irq_ack) ? (N_SRC'(1) << irq_vec) : '0;

  irqc_nmi_src nmi_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (nmi_s),
    .rise_sel (nmi_rise_q),
    .clr      (clr[0]),
    .set      (nmi_set),
    .pend     (nmi_pend)
  );
  assign src_req[0] = nmi_pend;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irqc_ext_src src_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (ext_s[g]),
      .en        (ext_en_q[g]),
      .edge_mode (ext_edge_q[g]),
      .clr       (clr[1 + g]),
      .req       (src_req[1 + g])
    );
  end

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_per
    assign src_req[PER_BASE + g] = per_en_q[g] & periph_req[g];
  end

  assign arb_req = {src_req[N_SRC-1:1] & {(N_SRC - 1){~mask_i}}, src_req[0]};

  irqc_prio #(.N(N_SRC), .W(VEC_W)) prio_i (
    .req (arb_req),
    .any (irq_valid),
    .idx (irq_vec)
  );

  assign irq_nmi = irq_valid && (irq_vec == '0);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC = 17,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_i,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_nmi,
  input logic             irq_ack,
  input logic             nmi_set,
  input logic             nmi_pend
);
  AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> nmi_pend); // R2
  AST_NMI_ALWAYS_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_valid && irq_nmi)); // R3
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !(irq_valid && irq_ack)) |=> nmi_pend); // R4
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_vec) < N_SRC)); // R8
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && irq_valid) |-> irq_nmi); // R10
  AST_NMI_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_nmi && irq_ack && !nmi_set) |=> !nmi_pend); // R12
endmodule

bind irq_gate_ctrl irqc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mask_i    (mask_i),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec),
  .irq_nmi   (irq_nmi),
  .irq_ack   (irq_ack),
  .nmi_set   (nmi_set),
  .nmi_pend  (nmi_pend)
);

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       nmi_pin = 1'b1;
  logic [7:0] ext_pin = 8'hFF;
  logic [7:0] periph_req = '0;
  logic       mask_i = 1'b0;
  logic       irq_valid;
  logic [4:0] irq_vec;
  logic       irq_nmi;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nmi_pin(nmi_pin), .ext_pin(ext_pin), .periph_req(periph_req), .mask_i(mask_i),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_nmi(irq_nmi), .irq_ack(irq_ack)
  );

  // ext[7:0], periph[7:0], mask, expected valid, expected vector
  localparam logic [22:0] TBL [9] = '{
    {8'hFF, 8'h00, 1'b0, 1'b0, 5'd0},
    {8'hFE, 8'h00, 1'b0, 1'b1, 5'd1},
    {8'h7F, 8'h00, 1'b0, 1'b1, 5'd8},
    {8'hDB, 8'h00, 1'b0, 1'b1, 5'd3},
    {8'hFF, 8'h01, 1'b0, 1'b1, 5'd9},
    {8'hFF, 8'hA0, 1'b0, 1'b1, 5'd14},
    {8'hEF, 8'h01, 1'b0, 1'b1, 5'd5},
    {8'h00, 8'hFF, 1'b1, 1'b0, 5'd0},
    {8'hFF, 8'h80, 1'b0, 1'b1, 5'd16}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic ev, input logic [4:0] evec, input logic enmi);
    checks++;
    if (irq_valid !== ev || (ev && (irq_vec !== evec || irq_nmi !== enmi))) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d nmi=%0b expected valid=%0b vec=%0d nmi=%0b",
               tag, irq_valid, irq_vec, irq_nmi, ev, evec, enmi);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ext(input int i);
    ext_pin[i] = 1'b0;
    cyc(2);
    ext_pin[i] = 1'b1;
    cyc(3);
  endtask

  task automatic pulse_nmi();
    nmi_pin = 1'b0;
    cyc(2);
    nmi_pin = 1'b1;
    cyc(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 idle after reset", 1'b0, 5'd0, 1'b0);
    ext_pin[0] = 1'b0;
    cyc(3);
    chk("R1/R7 pin0 low but disabled", 1'b0, 5'd0, 1'b0);
    cfg(2'd0, 8'hFF);
    chk("R11 enable write exposes level pin0", 1'b1, 5'd1, 1'b0);
    ext_pin[0] = 1'b1;
    cfg(2'd2, 8'hFF);
    cyc(3);

    // Table walk: level-mode pins and peripheral lines
    for (int k = 0; k < 9; k++) begin
      logic [22:0] ent;
      ent = TBL[k];
      ext_pin = ent[22:15]; periph_req = ent[14:7]; mask_i = ent[6];
      cyc(3);
      chk($sformatf("R8/R5/R10 table row %0d", k), ent[5], ent[4:0], 1'b0);
    end
    ext_pin = 8'hFF; periph_req = '0; mask_i = 1'b0;
    cfg(2'd2, 8'h00);
    cfg(2'd1, 8'hFF);
    cyc(3);
    chk("R11 all quiet in edge mode", 1'b0, 5'd0, 1'b0);

    // R6 edge latch survives pin release
    pulse_ext(2);
    chk("R6 edge latched on pin2", 1'b1, 5'd3, 1'b0);
    ack();
    chk("R6 latch cleared by ack", 1'b0, 5'd0, 1'b0);

    // R9 loser stays pending
    ext_pin[1] = 1'b0; ext_pin[4] = 1'b0;
    cyc(2);
    ext_pin = 8'hFF;
    cyc(3);
    chk("R9 pin1 wins over pin4", 1'b1, 5'd2, 1'b0);
    ack();
    chk("R9 pin4 still pending", 1'b1, 5'd5, 1'b0);
    ack();
    chk("R12 ack cleared only presented source", 1'b0, 5'd0, 1'b0);

    // R7 edge on a disabled pin is not latched
    cfg(2'd0, 8'hF7);
    pulse_ext(3);
    chk("R7 disabled pin3 edge", 1'b0, 5'd0, 1'b0);
    cfg(2'd0, 8'hFF);
    chk("R7 enable afterwards shows nothing", 1'b0, 5'd0, 1'b0);

    // R10 / R12 mask holds request, ack while idle ignored
    mask_i = 1'b1;
    pulse_ext(0);
    chk("R10 masked pin0 hidden", 1'b0, 5'd0, 1'b0);
    ack();
    mask_i = 1'b0;
    #1;
    chk("R12 ack with valid low ignored", 1'b1, 5'd1, 1'b0);
    ack();
    chk("R6 pin0 cleared", 1'b0, 5'd0, 1'b0);

    // R3 non-maskable bypasses mask
    mask_i = 1'b1;
    pulse_nmi();
    chk("R3 nmi shown under mask", 1'b1, 5'd0, 1'b1);
    ack();
    chk("R12 nmi cleared by ack", 1'b0, 5'd0, 1'b0);

    // R4 merge of two edges
    pulse_nmi();
    pulse_nmi();
    chk("R4 nmi pending after two edges", 1'b1, 5'd0, 1'b1);
    ack();
    chk("R4 one ack clears merged nmi", 1'b0, 5'd0, 1'b0);

    // R2 rising-edge selection
    cfg(2'd3, 8'h01);
    nmi_pin = 1'b0;
    cyc(4);
    chk("R2 falling edge ignored in rise mode", 1'b0, 5'd0, 1'b0);
    nmi_pin = 1'b1;
    cyc(4);
    chk("R2 rising edge sets nmi", 1'b1, 5'd0, 1'b1);
    ack();
    chk("R2 nmi cleared", 1'b0, 5'd0, 1'b0);

    // R8 nmi over external
    mask_i = 1'b0;
    pulse_ext(0);
    nmi_pin = 1'b0;
    cyc(3);
    nmi_pin = 1'b1;
    cyc(4);
    chk("R8 nmi beats pin0", 1'b1, 5'd0, 1'b1);
    ack();
    chk("R9 pin0 follows nmi", 1'b1, 5'd1, 1'b0);
    ack();
    chk("R9 all cleared", 1'b0, 5'd0, 1'b0);

    // R5 level mode not cleared by ack
    cfg(2'd1, 8'h00);
    ext_pin[6] = 1'b0;
    cyc(3);
    chk("R5 level pin6", 1'b1, 5'd7, 1'b0);
    ack();
    chk("R5 ack leaves level request", 1'b1, 5'd7, 1'b0);
    ext_pin[6] = 1'b1;
    cyc(3);
    chk("R5 request follows pin", 1'b0, 5'd0, 1'b0);

    finish_run();
  end
endmodule